// File: doc/BRIEF.md
# Table Entry Locator and Writer

This block takes the ID of a table entry and the table's configuration, works out where that entry lives in memory, and writes a 64-bit entry word there. The configuration is a base address, a flag that selects flat or two-level indexing, a two-bit page-size code and the log2 of the entry size in bytes. In flat mode the entry address comes straight from the base and the ID. In two-level mode the block first fetches an 8-byte level-1 descriptor through a 64-bit read port. If the descriptor is marked valid, the block derives the level-2 page from it and then writes the entry into its slot in that page.

A command processor pulses `start` with the ID, configuration and entry word. It then waits for the one-cycle `done` pulse. Two flags are valid alongside `done`. `skipped` reports a level-1 descriptor that was not valid, in which case nothing was written. `err` reports a memory error on either the read or the write, so that the caller can stall its queue. Each memory request stays asserted, with a stable address, until the memory returns its acknowledge. The acknowledge carries an error bit.

Top module: `tbl_entry_locator`

## Requirements
- R1: With `cfg_indirect`=0, the block performs no read. It performs exactly one write at `cfg_base + tbl_id * 2^cfg_esz_log2`, then pulses `done` with `skipped`=0 and `err`=0.
- R2: With `cfg_indirect`=1, the page size is 4096 bytes for code 0, 16384 for code 1, and 65536 for codes 2 and 3. The single descriptor read goes to `cfg_base + (tbl_id / (page/8)) * 8`.
- R3: If the descriptor's bit 63 is 0, no write is issued, and `done` pulses with `skipped`=1 and `err`=0.
- R4: The level-2 page base is descriptor bits [51:0] with bits below log2(page) forced to zero. Bits [62:52] of the descriptor do not affect the write address.
- R5: With a valid descriptor, the write address is `page_base + (tbl_id mod (page / 2^cfg_esz_log2)) * 2^cfg_esz_log2`.
- R6: `wr_data` byte lane k (bits 8k+7:8k) carries bits 8k+7:8k of the `entry_word` sampled at the accepted `start` (little-endian). A later change of `entry_word` has no effect on the write.
- R7: A read acknowledged with `rd_err`=1 ends the operation with `done`, `err`=1, `skipped`=0 and no write.
- R8: A write acknowledged with `wr_err`=1 ends the operation with `done` and `err`=1.
- R9: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after an accepted `start` up to and including the `done` cycle. A `start` while `busy` is ignored.
- R10: After reset `busy`, `done`, `rd_req` and `wr_req` are low.
- R11: `rd_req` and `wr_req` stay high, with `rd_addr` and `wr_addr` stable, until the matching acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| tbl_id | input | IDW | Entry ID |
| cfg_base | input | AW | Table base (level-1 base in two-level mode) |
| cfg_indirect | input | 1 | 1 selects two-level indexing |
| cfg_page_code | input | 2 | Page-size code |
| cfg_esz_log2 | input | 3 | log2 of entry size in bytes (3 to 6) |
| entry_word | input | 64 | Entry value to store |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 64 | Descriptor read data |
| rd_err | input | 1 | Read error, valid with `rd_ack` |
| wr_req | output | 1 | Entry write request |
| wr_addr | output | AW | Entry address |
| wr_data | output | 64 | Entry data, little-endian lanes |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, valid with `wr_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| skipped | output | 1 | Invalid descriptor, valid with `done` |
| err | output | 1 | Memory error, valid with `done` |

## Verification
The bench runs every page-size code, including code 3. A design that treated code 3 as a fourth size, or shifted the index by the wrong amount, would read a descriptor from the wrong address. It also uses descriptors that have stray high bits and low bits that are not page aligned. A design that took the level-2 base as a shifted field, or left those bits unmasked, would write outside the intended page. Invalid descriptors and errors on the read and on the write are injected. A wrong design would then issue a write it should not, or leave the wrong flag set. Finally, a second `start` and a changed entry word are applied while the block is busy, and the acknowledges are delayed. This exposes a design that restarts mid-operation, takes its data late, or lets a request address move before the acknowledge.

// File: rtl/tel_pkg.sv
package tel_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FETCH  = 2'd1,
      ST_STORE  = 2'd2,
      ST_FINISH = 2'd3
   } tel_state_e;

   localparam int DESC_BYTES_LOG2 = 3;
   localparam int DESC_VALID_BIT  = 63;
   localparam int DESC_ADDR_TOP   = 51;
   localparam int WORD_BYTES      = 8;

   // Page shift for a page-size code; codes 2 and 3 share the largest page.
   function automatic int page_shift(input logic [1:0] code);
      case (code)
         2'd0:    return 12;
         2'd1:    return 14;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/tel_l1_index.sv
module tel_l1_index #(
   parameter int AW  = 52,
   parameter int IDW = 20
) (
   input  logic [AW-1:0]  base,
   input  logic [IDW-1:0] id,
   input  logic [1:0]     code,
   input  logic [2:0]     esz_log2,
   output logic [AW-1:0]  flat_addr,
   output logic [AW-1:0]  desc_addr
);
   localparam int NCODES = 4;

   logic [AW-1:0] cand [NCODES];

   // One descriptor-address candidate per page-size code, each a fixed shift.
   genvar c;
   generate
      for (c = 0; c < NCODES; c++) begin : g_code
         localparam int PS    = tel_pkg::page_shift(2'(c));
         localparam int IXSH  = PS - tel_pkg::DESC_BYTES_LOG2;
         logic [IDW-1:0] l1_idx;
         assign l1_idx  = id >> IXSH;
         assign cand[c] = base + (AW'(l1_idx) << tel_pkg::DESC_BYTES_LOG2);
      end
   endgenerate

   assign desc_addr = cand[code];
   assign flat_addr = base + (AW'(id) << esz_log2);

endmodule

// File: rtl/tel_l2_slot.sv
module tel_l2_slot #(
   parameter int AW  = 52,
   parameter int IDW = 20
) (
   input  logic [63:0]    desc,
   input  logic [IDW-1:0] id,
   input  logic [1:0]     code,
   input  logic [2:0]     esz_log2,
   output logic           desc_valid,
   output logic [AW-1:0]  entry_addr
);
   logic [4:0]    ps;
   logic [4:0]    slot_sh;
   logic [AW-1:0] page_mask;
   logic [AW-1:0] slot_mask;
   logic [AW-1:0] page_base;
   logic [AW-1:0] slot_off;
   logic          unused_desc_bits;

   assign ps        = 5'(tel_pkg::page_shift(code));
   assign slot_sh   = ps - {2'b00, esz_log2};
   assign page_mask = (AW'(1) << ps) - AW'(1);
   assign slot_mask = (AW'(1) << slot_sh) - AW'(1);

   // Level-2 base is the descriptor address field itself, page offset cleared.
   assign page_base  = desc[AW-1:0] & ~page_mask;
   assign slot_off   = (AW'(id) & slot_mask) << esz_log2;
   assign entry_addr = page_base + slot_off;
   assign desc_valid = desc[tel_pkg::DESC_VALID_BIT];

   assign unused_desc_bits = ^desc[tel_pkg::DESC_VALID_BIT-1:AW];

endmodule

// File: rtl/tel_ctrl.sv
module tel_ctrl
   import tel_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       indirect,
   input  logic       rd_ack,
   input  logic       rd_err,
   input  logic       desc_valid,
   input  logic       wr_ack,
   input  logic       wr_err,
   output tel_state_e state,
   output logic       accept,
   output logic       l2_load,
   output logic       skip_q,
   output logic       err_q
);
   tel_state_e nxt;

   assign accept  = (state == ST_IDLE) && start;
   assign l2_load = (state == ST_FETCH) && rd_ack && !rd_err && desc_valid;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:   if (start) nxt = indirect ? ST_FETCH : ST_STORE;
         ST_FETCH:  if (rd_ack) nxt = (rd_err || !desc_valid) ? ST_FINISH : ST_STORE;
         ST_STORE:  if (wr_ack) nxt = ST_FINISH;
         ST_FINISH: nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         skip_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (accept) begin
            skip_q <= 1'b0;
            err_q  <= 1'b0;
         end else if (state == ST_FETCH && rd_ack) begin
            err_q  <= rd_err;
            skip_q <= !rd_err && !desc_valid;
         end else if (state == ST_STORE && wr_ack) begin
            err_q  <= wr_err;
         end
      end
   end

endmodule

// File: rtl/tbl_entry_locator.sv
module tbl_entry_locator
   import tel_pkg::*;
#(
   parameter int AW  = 52,
   parameter int IDW = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [IDW-1:0] tbl_id,
   input  logic [AW-1:0]  cfg_base,
   input  logic           cfg_indirect,
   input  logic [1:0]     cfg_page_code,
   input  logic [2:0]     cfg_esz_log2,
   input  logic [63:0]    entry_word,
   output logic           rd_req,
   output logic [AW-1:0]  rd_addr,
   input  logic           rd_ack,
   input  logic [63:0]    rd_data,
   input  logic           rd_err,
   output logic           wr_req,
   output logic [AW-1:0]  wr_addr,
   output logic [63:0]    wr_data,
   input  logic           wr_ack,
   input  logic           wr_err,
   output logic           busy,
   output logic           done,
   output logic           skipped,
   output logic           err
);
   generate
      if (AW < 17 || AW > DESC_ADDR_TOP + 1) begin : g_bad_aw
         $error("tbl_entry_locator: AW must be 17..52");
      end
      if (IDW < 1 || IDW + 6 > AW) begin : g_bad_idw
         $error("tbl_entry_locator: IDW must be 1..AW-6");
      end
   endgenerate

   tel_state_e     state;
   logic           accept;
   logic           l2_load;
   logic           skip_q;
   logic           err_q;
   logic           desc_valid;

   logic [IDW-1:0] id_q;
   logic [AW-1:0]  base_q;
   logic           ind_q;
   logic [1:0]     code_q;
   logic [2:0]     esz_q;
   logic [63:0]    entry_q;
   logic [AW-1:0]  l2_addr_q;

   logic [AW-1:0]  flat_addr;
   logic [AW-1:0]  desc_addr;
   logic [AW-1:0]  l2_addr;

   tel_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .indirect   (cfg_indirect),
      .rd_ack     (rd_ack),
      .rd_err     (rd_err),
      .desc_valid (desc_valid),
      .wr_ack     (wr_ack),
      .wr_err     (wr_err),
      .state      (state),
      .accept     (accept),
      .l2_load    (l2_load),
      .skip_q     (skip_q),
      .err_q      (err_q)
   );

   tel_l1_index #(.AW(AW), .IDW(IDW)) u_l1 (
      .base      (base_q),
      .id        (id_q),
      .code      (code_q),
      .esz_log2  (esz_q),
      .flat_addr (flat_addr),
      .desc_addr (desc_addr)
   );

   tel_l2_slot #(.AW(AW), .IDW(IDW)) u_l2 (
      .desc       (rd_data),
      .id         (id_q),
      .code       (code_q),
      .esz_log2   (esz_q),
      .desc_valid (desc_valid),
      .entry_addr (l2_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q      <= '0;
         base_q    <= '0;
         ind_q     <= 1'b0;
         code_q    <= '0;
         esz_q     <= 3'd3;
         entry_q   <= '0;
         l2_addr_q <= '0;
      end else begin
         if (accept) begin
            id_q    <= tbl_id;
            base_q  <= cfg_base;
            ind_q   <= cfg_indirect;
            code_q  <= cfg_page_code;
            esz_q   <= cfg_esz_log2;
            entry_q <= entry_word;
         end
         if (l2_load) l2_addr_q <= l2_addr;
      end
   end

   // Little-endian lane placement: lane k holds entry byte k.
   genvar k;
   generate
      for (k = 0; k < WORD_BYTES; k++) begin : g_lane
         assign wr_data[8*k +: 8] = entry_q[8*k +: 8];
      end
   endgenerate

   assign rd_req  = (state == ST_FETCH);
   assign rd_addr = desc_addr;
   assign wr_req  = (state == ST_STORE);
   assign wr_addr = ind_q ? l2_addr_q : flat_addr;
   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_FINISH);
   assign skipped = done && skip_q;
   assign err     = done && err_q;

endmodule

// File: rtl/tel_checker.sv
module tel_checker #(
   parameter int AW  = 52,
   parameter int IDW = 20
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [IDW-1:0] tbl_id,
   input logic           cfg_indirect,
   input logic [1:0]     cfg_page_code,
   input logic [2:0]     cfg_esz_log2,
   input logic           rd_req,
   input logic [AW-1:0]  rd_addr,
   input logic           rd_ack,
   input logic [63:0]    rd_data,
   input logic           rd_err,
   input logic           wr_req,
   input logic [AW-1:0]  wr_addr,
   input logic           wr_ack,
   input logic           busy,
   input logic           done,
   input logic           skipped,
   input logic           err
);
   logic          ind_cap;
   logic [1:0]    code_cap;
   logic [2:0]    esz_cap;
   logic [63:0]   desc_cap;
   logic          no_write_due;
   logic [AW-1:0] pmask;
   logic [AW-1:0] emask;
   logic          unused_chk;

   assign unused_chk = ^tbl_id;
   assign pmask = (AW'(1) << tel_pkg::page_shift(code_cap)) - AW'(1);
   assign emask = (AW'(1) << esz_cap) - AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ind_cap      <= 1'b0;
         code_cap     <= '0;
         esz_cap      <= '0;
         desc_cap     <= '0;
         no_write_due <= 1'b0;
      end else begin
         if (start && !busy) begin
            ind_cap      <= cfg_indirect;
            code_cap     <= cfg_page_code;
            esz_cap      <= cfg_esz_log2;
            no_write_due <= 1'b0;
         end else if (rd_req && rd_ack) begin
            desc_cap     <= rd_data;
            no_write_due <= rd_err || !rd_data[63];
         end
      end
   end

   p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req && !wr_req && !done));

   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_flat_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ind_cap) |-> !rd_req);

   p_no_write_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ind_cap && no_write_due) |-> !wr_req);

   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(skipped && err));

   p_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && ind_cap) |-> ((wr_addr & ~pmask) == (desc_cap[AW-1:0] & ~pmask)));

   p_slot_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && ind_cap) |-> ((wr_addr & emask) == '0));

endmodule

bind tbl_entry_locator tel_checker #(.AW(AW), .IDW(IDW)) chk_i (.*);

// File: tb/tbl_entry_locator_tb_top.sv
module tbl_entry_locator_tb_top;
   localparam int AW  = 52;
   localparam int IDW = 20;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [IDW-1:0] tbl_id = '0;
   logic [AW-1:0]  cfg_base = '0;
   logic           cfg_indirect = 1'b0;
   logic [1:0]     cfg_page_code = '0;
   logic [2:0]     cfg_esz_log2 = 3'd3;
   logic [63:0]    entry_word = '0;
   logic           rd_req;
   logic [AW-1:0]  rd_addr;
   logic           rd_ack = 1'b0;
   logic [63:0]    rd_data = '0;
   logic           rd_err = 1'b0;
   logic           wr_req;
   logic [AW-1:0]  wr_addr;
   logic [63:0]    wr_data;
   logic           wr_ack = 1'b0;
   logic           wr_err = 1'b0;
   logic           busy, done, skipped, err;

   tbl_entry_locator #(.AW(AW), .IDW(IDW)) dut_i (.*);

   always #5 clk = ~clk;

   // memory model
   logic [63:0] mem [logic [AW-1:0]];
   int          n_reads = 0, n_writes = 0;
   int          ack_delay = 0;
   int          rd_wait = 0, wr_wait = 0;
   bit          fail_rd = 0, fail_wr = 0;
   logic [AW-1:0] last_rd_addr = '0, last_wr_addr = '0;
   logic [63:0]   last_wr_data = '0;

   always @(negedge clk) begin
      if (rd_ack) begin
         rd_ack = 1'b0; rd_err = 1'b0;
      end else if (rd_req) begin
         if (rd_wait < ack_delay) rd_wait++;
         else begin
            rd_wait = 0;
            rd_ack  = 1'b1;
            rd_err  = fail_rd;
            rd_data = mem.exists(rd_addr) ? mem[rd_addr] : 64'd0;
            last_rd_addr = rd_addr;
            n_reads++;
         end
      end
      if (wr_ack) begin
         wr_ack = 1'b0; wr_err = 1'b0;
      end else if (wr_req) begin
         if (wr_wait < ack_delay) wr_wait++;
         else begin
            wr_wait = 0;
            wr_ack  = 1'b1;
            wr_err  = fail_wr;
            last_wr_addr = wr_addr;
            last_wr_data = wr_data;
            n_writes++;
         end
      end
   end

   int  n_cmp = 0, n_bad = 0;
   bit  finished = 0;

   task automatic chk(input bit ok, input string req, input longint unsigned act,
                      input longint unsigned exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic longint unsigned pg_bytes(input int code);
      if (code == 0) return 64'd4096;
      if (code == 1) return 64'd16384;
      return 64'd65536;
   endfunction

   function automatic longint unsigned exp_desc_addr(input longint unsigned base,
         input longint unsigned id, input int code);
      longint unsigned pg = pg_bytes(code);
      return (base + (id / (pg / 8)) * 8) & 64'hF_FFFF_FFFF_FFFF;
   endfunction

   function automatic longint unsigned exp_l2_addr(input longint unsigned desc,
         input longint unsigned id, input int code, input int esz_log2);
      longint unsigned pg = pg_bytes(code);
      longint unsigned es = 64'd1 << esz_log2;
      longint unsigned pb = desc & 64'hF_FFFF_FFFF_FFFF;
      pb = pb - (pb % pg);
      return pb + (id % (pg / es)) * es;
   endfunction

   // results of last command
   bit r_skip, r_err, r_to;
   int r_reads, r_writes;

   task automatic do_cmd(input logic [IDW-1:0] id, input logic [AW-1:0] base,
                         input bit ind, input logic [1:0] code, input logic [2:0] esz,
                         input logic [63:0] ent);
      int rd0 = n_reads, wr0 = n_writes, t = 0;
      tbl_id = id; cfg_base = base; cfg_indirect = ind;
      cfg_page_code = code; cfg_esz_log2 = esz; entry_word = ent;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && t < 200) begin @(negedge clk); t++; end
      r_to = !done; r_skip = skipped; r_err = err;
      @(negedge clk);
      chk(!r_to && !done, "R9 done single pulse", {63'd0, done}, 64'd0);
      r_reads = n_reads - rd0; r_writes = n_writes - wr0;
   endtask

   task automatic t_reset();
      chk(!busy && !done && !rd_req && !wr_req, "R10 reset idle",
          {60'd0, busy, done, rd_req, wr_req}, 64'd0);
   endtask

   task automatic t_flat();
      logic [IDW-1:0] ids [3] = '{20'h00000, 20'h5A3C7, 20'hFFFFF};
      logic [2:0]     ess [3] = '{3'd3, 3'd4, 3'd6};
      for (int i = 0; i < 3; i++) begin
         longint unsigned base = 64'h0_1234_5670_0000;
         longint unsigned exp = base + longint'(ids[i]) * (64'd1 << ess[i]);
         logic [63:0] ent = 64'h1122_3344_5566_7788 ^ longint'(i);
         do_cmd(ids[i], base[AW-1:0], 1'b0, 2'd0, ess[i], ent);
         chk(r_reads == 0 && r_writes == 1 && !r_skip && !r_err, "R1 flat flow",
             longint'(r_reads * 16 + r_writes), 64'd1);
         chk(longint'(last_wr_addr) == exp, "R1 flat address", longint'(last_wr_addr), exp);
         chk(last_wr_data[7:0] == ent[7:0] && last_wr_data[63:56] == ent[63:56]
             && last_wr_data == ent, "R6 lane order", last_wr_data, ent);
      end
   endtask

   task automatic t_codes();
      for (int code = 0; code < 4; code++) begin
         longint unsigned base = 64'h0_0008_0000_0000;
         longint unsigned id   = 64'h5A3C7;
         longint unsigned da   = exp_desc_addr(base, id, code);
         longint unsigned desc = 64'h8000_0000_0000_0000 | (64'h0_00AB_CD00_0000 + 64'h10000 * code);
         longint unsigned ea   = exp_l2_addr(desc, id, code, 4);
         mem[da[AW-1:0]] = desc;
         do_cmd(id[IDW-1:0], base[AW-1:0], 1'b1, 2'(code), 3'd4, 64'hDEAD_0000_0000_BEEF);
         chk(r_reads == 1 && longint'(last_rd_addr) == da, "R2 descriptor address",
             longint'(last_rd_addr), da);
         chk(r_writes == 1 && !r_skip && !r_err && longint'(last_wr_addr) == ea,
             "R5 level-2 slot address", longint'(last_wr_addr), ea);
      end
   endtask

   task automatic t_desc_bits();
      longint unsigned base = 64'h0_0010_0000_0000;
      longint unsigned id   = 64'h0FFFF;
      longint unsigned desc = 64'hFFF0_0012_3456_7ABC;
      longint unsigned da   = exp_desc_addr(base, id, 1);
      longint unsigned ea   = exp_l2_addr(desc, id, 1, 3);
      mem[da[AW-1:0]] = desc;
      do_cmd(id[IDW-1:0], base[AW-1:0], 1'b1, 2'd1, 3'd3, 64'h0123_4567_89AB_CDEF);
      chk(r_writes == 1 && longint'(last_wr_addr) == ea, "R4 page base masking",
          longint'(last_wr_addr), ea);
   endtask

   task automatic t_invalid();
      longint unsigned base = 64'h0_0020_0000_0000;
      longint unsigned id   = 64'h01234;
      longint unsigned da   = exp_desc_addr(base, id, 2);
      mem[da[AW-1:0]] = 64'h7FFF_FFFF_FFFF_0000;
      do_cmd(id[IDW-1:0], base[AW-1:0], 1'b1, 2'd2, 3'd3, 64'h1);
      chk(r_skip && !r_err && r_writes == 0, "R3 invalid descriptor skipped",
          {62'd0, r_skip, r_err} + longint'(r_writes * 4), 64'd2);
   endtask

   task automatic t_rd_err();
      longint unsigned base = 64'h0_0030_0000_0000;
      longint unsigned da   = exp_desc_addr(base, 64'h7, 0);
      mem[da[AW-1:0]] = 64'h8000_0000_0040_0000;
      fail_rd = 1;
      do_cmd(20'h7, base[AW-1:0], 1'b1, 2'd0, 3'd3, 64'h2);
      fail_rd = 0;
      chk(r_err && !r_skip && r_writes == 0, "R7 read error",
          {62'd0, r_skip, r_err} + longint'(r_writes * 4), 64'd1);
   endtask

   task automatic t_wr_err();
      fail_wr = 1;
      do_cmd(20'h9, 52'h0_0040_0000_0000, 1'b0, 2'd0, 3'd3, 64'h3);
      fail_wr = 0;
      chk(r_err && !r_skip && r_writes == 1, "R8 write error",
          {62'd0, r_skip, r_err} + longint'(r_writes * 4), 64'd5);
   endtask

   task automatic t_busy_hold();
      longint unsigned base = 64'h0_0050_0000_0000;
      longint unsigned id   = 64'h2345;
      longint unsigned da   = exp_desc_addr(base, id, 3);
      longint unsigned desc = 64'h8000_0000_0770_0000;
      longint unsigned ea   = exp_l2_addr(desc, id, 3, 5);
      logic [63:0] ent0 = 64'hCAFE_F00D_1234_5678;
      int wr0 = n_writes, t = 0;
      bit stable_ok = 1, busy_ok = 1;
      mem[da[AW-1:0]] = desc;
      ack_delay = 3;
      tbl_id = id[IDW-1:0]; cfg_base = base[AW-1:0]; cfg_indirect = 1'b1;
      cfg_page_code = 2'd3; cfg_esz_log2 = 3'd5; entry_word = ent0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      busy_ok = busy;
      tbl_id = 20'h00001; cfg_indirect = 1'b0; entry_word = 64'h0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && t < 200) begin
         if (rd_req && !rd_ack && longint'(rd_addr) != da) stable_ok = 0;
         if (wr_req && !wr_ack && longint'(wr_addr) != ea) stable_ok = 0;
         if (!busy) busy_ok = 0;
         @(negedge clk); t++;
      end
      chk(done && busy, "R9 busy through done", {62'd0, done, busy}, 64'd3);
      @(negedge clk);
      @(negedge clk);
      ack_delay = 0;
      chk(stable_ok, "R11 request held stable", {63'd0, stable_ok}, 64'd1);
      chk(busy_ok && n_writes - wr0 == 1 && longint'(last_wr_addr) == ea,
          "R9 start while busy ignored", longint'(last_wr_addr), ea);
      chk(last_wr_data == ent0, "R6 entry sampled at start", last_wr_data, ent0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flat();
      t_codes();
      t_desc_bits();
      t_invalid();
      t_rd_err();
      t_wr_err();
      t_busy_hold();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule